// File: doc/BRIEF.md
# I2C Packet Error Check Unit

This block gives a byte-oriented I2C engine a CRC-8 packet error check of the kind used on SMBus. The engine reports each byte that crosses the bus with a one-cycle valid strobe, the byte value and a direction flag. The unit folds every byte into a running CRC-8 that starts at zero on each start or repeated start. The address byte with its read/write bit is included. The running CRC is always available on `crc_value`, so the engine can load it as the next transmit byte.

Software arms checking through `pec_set`. When the unit transmits and the engine marks the final data byte, `pec_send` rises. The engine then sends `crc_value` as one more byte, and that byte clears both `pec_send` and the enable. When the unit receives, the byte marked last is taken as the sender's CRC and compared with the running value. A mismatch requests a NAK and sets a sticky error flag. A master receiver always NAKs its final byte. Start, stop, arbitration loss and a disabled peripheral each drop the enable.

All outputs are registered. Each outcome appears on the outputs in the cycle after the strobe or event that causes it.

Top module: `i2c_pec_unit`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `crc_value` is 0x00, and `pec_en`, `pec_send`, `nak_req` and `pec_err` are all 0.
- R2: Every accepted byte that is not a CRC byte replaces `crc_value` one cycle later with CRC-8 of that byte. The polynomial is 0x07 (x^8+x^2+x+1), bits are processed MSB first, and the old value is the seed. So 0x01 from zero gives 0x07, and ASCII "123456789" from zero gives 0xF4. This holds whether or not checking is enabled, and address bytes are included.
- R3: `start_evt` clears `crc_value` to 0x00 and clears `pec_en` and `pec_send`. A byte strobed in the same cycle is ignored.
- R4: With `pec_en` at 1, a transmitted byte marked `last_byte` sets `pec_send`. The next transmitted byte is the CRC byte: it clears `pec_send` and `pec_en` and leaves `crc_value` unchanged.
- R5: With `pec_en` at 1, a received byte marked `last_byte` is compared with `crc_value` and does not alter it. On a mismatch, `nak_req` and `pec_err` both rise in the next cycle. On a match in slave mode (`is_master`=0), neither rises.
- R6: A received byte marked `last_byte` while `is_master`=1 raises `nak_req` in the next cycle, whether the check matches, fails or is disabled.
- R7: `pec_err` stays at 1 until `err_clr`. If a new mismatch arrives in the same cycle as `err_clr`, the flag stays set.
- R8: `stop_evt` clears `pec_en` and `pec_send`, keeps `crc_value`, and causes a same-cycle byte to be ignored.
- R9: `arb_lost` clears `crc_value`, `pec_en` and `pec_send`.
- R10: While `core_en` is 0, `crc_value`, `pec_en` and `pec_send` are cleared, and `pec_set` has no effect.
- R11: `nak_req` is high for exactly one cycle for each received last byte that calls for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_en | input | 1 | Peripheral enable; 0 clears checking state |
| pec_set | input | 1 | Software pulse that arms checking |
| err_clr | input | 1 | Software pulse that clears the sticky error |
| start_evt | input | 1 | Start or repeated start seen/generated |
| stop_evt | input | 1 | Stop seen/generated |
| arb_lost | input | 1 | Arbitration lost |
| byte_vld | input | 1 | One-cycle strobe: a byte completed on the bus |
| byte_data | input | 8 | The byte that completed |
| byte_tx | input | 1 | 1 when this unit drove the byte, 0 when received |
| last_byte | input | 1 | Marks the last data byte (tx) or the CRC byte (rx) |
| is_master | input | 1 | 1 when the engine is bus master |
| crc_value | output | 8 | Running CRC-8 |
| pec_en | output | 1 | Checking enabled |
| pec_send | output | 1 | The next transmitted byte must be `crc_value` |
| nak_req | output | 1 | One-cycle NAK request for the byte just received |
| pec_err | output | 1 | Sticky receive-mismatch flag |

## Verification
The bench targets the seams between bytes and events. It strobes a byte in the same cycle as a start or a stop; a design that let the byte through would move the CRC away from zero or from its held value. It sends a CRC byte and checks that the CRC stays unchanged; a design that folded the CRC byte back in would show 0x00. It also checks that the enable drops after that byte, which a missing self-clear would leave high. It receives a deliberately wrong CRC while clearing the error flag in the same cycle; a design that gave priority to the clear would drop the flag. A master receiver with a correct CRC must still be NAKed, and a design that tied the NAK only to the mismatch would stay silent.

// File: rtl/pec_pkg.sv
// Shared parameters and types for the packet error check unit.
// Assumes an 8-bit CRC processed most significant bit first.
package pec_pkg;
    localparam int CRC_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    typedef logic [CRC_W-1:0] pec_word_t;
endpackage

// File: rtl/pec_crc_step.sv
// Combinational CRC update over one data word, MSB first.
// Assumes DATA_W data bits folded into a W-bit remainder with no reflection.
module pec_crc_step #(
    parameter int W = 8,
    parameter int DATA_W = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic [W-1:0]      crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [W-1:0]      crc_out
);
    logic [W-1:0] chain [DATA_W+1];

    assign chain[0] = crc_in;

    // one shift-and-xor stage per data bit, highest bit first
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic fb;
        assign fb = chain[i][W-1] ^ data_in[DATA_W-1-i];
        assign chain[i+1] = {chain[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = chain[DATA_W];
endmodule

// File: rtl/pec_ctrl.sv
// Enable and pending-CRC control. Decides which bytes are accepted,
// when the running CRC is cleared or advanced, and when checking self-clears.
// Assumes event inputs are single-cycle pulses from the bus engine.
module pec_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic core_en,
    input  logic pec_set,
    input  logic start_evt,
    input  logic stop_evt,
    input  logic arb_lost,
    input  logic byte_vld,
    input  logic byte_tx,
    input  logic last_byte,
    output logic crc_clear,
    output logic crc_advance,
    output logic rx_check,
    output logic rx_final,
    output logic pec_en,
    output logic pec_send
);
    logic hold, accept, tx_crc_byte, tx_final;

    assign crc_clear   = !core_en || arb_lost || start_evt;
    assign hold        = crc_clear || stop_evt;
    assign accept      = byte_vld && !hold;
    assign tx_crc_byte = accept && byte_tx && pec_send;
    assign tx_final    = accept && byte_tx && !pec_send && last_byte && pec_en;
    assign rx_final    = accept && !byte_tx && last_byte;
    assign rx_check    = rx_final && pec_en;
    assign crc_advance = accept && !tx_crc_byte && !rx_check;

    // enable bit: cleared by bus events or after the CRC byte, armed by software
    always_ff @(posedge clk) begin
        if (!rst_n)           pec_en <= 1'b0;
        else if (hold)        pec_en <= 1'b0;
        else if (tx_crc_byte) pec_en <= 1'b0;
        else if (pec_set)     pec_en <= 1'b1;
    end

    // pending flag: the next transmitted byte carries the CRC
    always_ff @(posedge clk) begin
        if (!rst_n)           pec_send <= 1'b0;
        else if (hold)        pec_send <= 1'b0;
        else if (tx_crc_byte) pec_send <= 1'b0;
        else if (tx_final)    pec_send <= 1'b1;
    end

    // R4
    send_implies_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pec_send |-> pec_en);
    // R10
    core_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |=> (!pec_en && !pec_send));
    // R8
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !pec_en);
endmodule

// File: rtl/pec_rx_check.sv
// Receive-side comparison of the final byte against the running CRC,
// producing a one-cycle NAK request and a sticky error flag.
// Assumes rx_final and rx_check are qualified by pec_ctrl.
module pec_rx_check #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_final,
    input  logic         rx_check,
    input  logic         is_master,
    input  logic         err_clr,
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] crc_cur,
    output logic         nak_req,
    output logic         pec_err
);
    logic mismatch;

    assign mismatch = rx_check && (rx_byte != crc_cur);

    // NAK pulse: mismatch, or the last byte of a master read
    always_ff @(posedge clk) begin
        if (!rst_n) nak_req <= 1'b0;
        else        nak_req <= mismatch || (rx_final && is_master);
    end

    // sticky error: a new mismatch takes priority over the clear
    always_ff @(posedge clk) begin
        if (!rst_n)        pec_err <= 1'b0;
        else if (mismatch) pec_err <= 1'b1;
        else if (err_clr)  pec_err <= 1'b0;
    end

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_err && !err_clr) |=> pec_err);
    // R5
    err_with_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pec_err) |-> nak_req);
endmodule

// File: rtl/i2c_pec_unit.sv
// Top of the packet error check unit: holds the running CRC register and
// joins control, CRC step and receive check.
// Assumes byte_vld is a single-cycle strobe per completed bus byte.
module i2c_pec_unit
    import pec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_en,
    input  logic       pec_set,
    input  logic       err_clr,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       arb_lost,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    input  logic       byte_tx,
    input  logic       last_byte,
    input  logic       is_master,
    output logic [7:0] crc_value,
    output logic       pec_en,
    output logic       pec_send,
    output logic       nak_req,
    output logic       pec_err
);
    pec_word_t crc_q, crc_nxt;
    logic crc_clear, crc_advance, rx_check, rx_final;

    pec_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .core_en(core_en), .pec_set(pec_set),
        .start_evt(start_evt), .stop_evt(stop_evt), .arb_lost(arb_lost),
        .byte_vld(byte_vld), .byte_tx(byte_tx), .last_byte(last_byte),
        .crc_clear(crc_clear), .crc_advance(crc_advance),
        .rx_check(rx_check), .rx_final(rx_final),
        .pec_en(pec_en), .pec_send(pec_send)
    );

    pec_crc_step #(.W(CRC_W), .DATA_W(8), .POLY(CRC_POLY)) u_step (
        .crc_in(crc_q), .data_in(byte_data), .crc_out(crc_nxt)
    );

    pec_rx_check #(.W(CRC_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_final(rx_final), .rx_check(rx_check),
        .is_master(is_master), .err_clr(err_clr), .rx_byte(byte_data),
        .crc_cur(crc_q), .nak_req(nak_req), .pec_err(pec_err)
    );

    // running CRC: zeroed on start, arbitration loss or disable; advanced per byte
    always_ff @(posedge clk) begin
        if (!rst_n)           crc_q <= '0;
        else if (crc_clear)   crc_q <= '0;
        else if (crc_advance) crc_q <= crc_nxt;
    end

    assign crc_value = crc_q;

    // R3
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (crc_value == 8'h00));
    // R11
    nak_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nak_req |-> $past(byte_vld && !byte_tx && last_byte));
    // R9
    arb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> (crc_value == 8'h00 && !pec_en));
endmodule

// File: tb/i2c_pec_unit_bench.sv
module i2c_pec_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 20000;

    logic clk = 0, rst_n = 0;
    logic core_en = 0, pec_set = 0, err_clr = 0, start_evt = 0, stop_evt = 0, arb_lost = 0;
    logic byte_vld = 0, byte_tx = 0, last_byte = 0, is_master = 0;
    logic [7:0] byte_data = 0;
    logic [7:0] crc_value;
    logic pec_en, pec_send, nak_req, pec_err;

    int n_checks = 0, n_errors = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_crc = 0;
    bit m_en = 0, m_send = 0, m_nak = 0, m_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_pec_unit u_i2c_pec_unit (
        .clk(clk), .rst_n(rst_n), .core_en(core_en), .pec_set(pec_set), .err_clr(err_clr),
        .start_evt(start_evt), .stop_evt(stop_evt), .arb_lost(arb_lost),
        .byte_vld(byte_vld), .byte_data(byte_data), .byte_tx(byte_tx),
        .last_byte(last_byte), .is_master(is_master),
        .crc_value(crc_value), .pec_en(pec_en), .pec_send(pec_send),
        .nak_req(nak_req), .pec_err(pec_err)
    );

    function automatic logic [7:0] crc8(input logic [7:0] seed, input logic [7:0] d);
        int acc = seed;
        for (int k = 7; k >= 0; k--) begin
            int top = ((acc >> 7) & 1) ^ ((d >> k) & 1);
            acc = (acc << 1) & 255;
            if (top != 0) acc = acc ^ 7;
        end
        return acc[7:0];
    endfunction

    task automatic check(input string tag, input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, crc_value == m_crc, "crc_value", crc_value, m_crc);
        check(tag, pec_en == m_en, "pec_en", pec_en, m_en);
        check(tag, pec_send == m_send, "pec_send", pec_send, m_send);
        check(tag, nak_req == m_nak, "nak_req", nak_req, m_nak);
        check(tag, pec_err == m_err, "pec_err", pec_err, m_err);
    endtask

    // model one clock from the inputs currently applied
    task automatic model_edge();
        bit clr = !core_en || arb_lost || start_evt;
        bit ignore = clr || stop_evt;
        bit take = byte_vld && !ignore;
        bit is_crc_tx = take && byte_tx && m_send;
        bit is_rx_last = take && !byte_tx && last_byte;
        bit bad = is_rx_last && m_en && (byte_data != m_crc);
        logic [7:0] n_crc = m_crc;
        bit n_en = m_en, n_send = m_send;
        if (clr) n_crc = 0;
        else if (take && !is_crc_tx && !(is_rx_last && m_en)) n_crc = crc8(m_crc, byte_data);
        if (ignore || is_crc_tx) begin n_en = 0; n_send = 0; end
        else begin
            if (pec_set) n_en = 1;
            if (take && byte_tx && last_byte && m_en) n_send = 1;
        end
        m_nak = bad || (is_rx_last && is_master);
        if (bad) m_err = 1; else if (err_clr) m_err = 0;
        m_crc = n_crc; m_en = n_en; m_send = n_send;
    endtask

    task automatic idle_inputs();
        pec_set = 0; err_clr = 0; start_evt = 0; stop_evt = 0; arb_lost = 0;
        byte_vld = 0; last_byte = 0;
    endtask

    // one clock: inputs held from negedge, model advances, outputs compared at next negedge
    task automatic tick(input string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        idle_inputs();
    endtask

    task automatic send(input logic [7:0] d, input bit tx, input bit last, input string tag);
        byte_vld = 1; byte_data = d; byte_tx = tx; last_byte = last;
        tick(tag);
    endtask

    task automatic do_start(input string tag);
        start_evt = 1; tick(tag);
    endtask

    task automatic arm(input string tag);
        pec_set = 1; tick(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] good;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        compare("R1");
        check("R1", crc_value == 8'h00 && !pec_en && !pec_send && !nak_req && !pec_err,
              "reset outputs", crc_value, 0);
        rst_n = 1; core_en = 1;
        tick("R1");

        // R2 anchor values
        do_start("R3");
        send(8'h01, 1, 0, "R2");
        check("R2", crc_value == 8'h07, "crc of 0x01", crc_value, 8'h07);
        do_start("R3");
        for (int i = 0; i < 9; i++) send(8'h31 + i[7:0], 1, 0, "R2");
        check("R2", crc_value == 8'hF4, "crc of 123456789", crc_value, 8'hF4);

        // R3 start clears, same-cycle byte ignored
        start_evt = 1; byte_vld = 1; byte_data = 8'h55; byte_tx = 1;
        tick("R3");
        check("R3", crc_value == 8'h00, "byte with start", crc_value, 0);

        // R4 transmit with CRC append
        arm("R4");
        send(8'hA0, 1, 0, "R2");
        send(8'h3C, 1, 0, "R2");
        send(8'h7F, 1, 1, "R4");
        check("R4", pec_send == 1, "pec_send after last", pec_send, 1);
        good = crc_value;
        send(good, 1, 0, "R4");
        check("R4", crc_value == good && !pec_en && !pec_send, "after crc byte", crc_value, good);

        // R5 slave receive, correct CRC -> no nak
        do_start("R3");
        arm("R5");
        send(8'hA1, 0, 0, "R2");
        send(8'h12, 0, 0, "R2");
        good = m_crc;
        send(good, 0, 1, "R5");
        check("R5", !nak_req && !pec_err, "match no nak", nak_req, 0);
        tick("R11");

        // R5/R7 wrong CRC with err_clr same cycle; R11 single pulse
        do_start("R3");
        arm("R5");
        send(8'hA1, 0, 0, "R2");
        err_clr = 1;
        send(m_crc ^ 8'h5A, 0, 1, "R7");
        check("R5", nak_req && pec_err, "mismatch nak+err", {nak_req, pec_err}, 3);
        tick("R11");
        check("R11", !nak_req, "nak one cycle", nak_req, 0);
        tick("R7");
        check("R7", pec_err, "error sticky", pec_err, 1);
        err_clr = 1; tick("R7");
        check("R7", !pec_err, "error cleared", pec_err, 0);

        // R6 master receive, correct CRC still NAKed; also with checking disabled
        do_start("R3");
        is_master = 1;
        arm("R6");
        send(8'hB3, 0, 0, "R2");
        send(m_crc, 0, 1, "R6");
        check("R6", nak_req && !pec_err, "master nak", nak_req, 1);
        do_start("R3");
        send(8'h44, 0, 1, "R6");
        check("R6", nak_req, "master nak disabled", nak_req, 1);
        is_master = 0;

        // R8 stop keeps crc, clears enable, ignores byte
        do_start("R3");
        arm("R8");
        send(8'h9E, 1, 1, "R4");
        good = crc_value;
        stop_evt = 1; byte_vld = 1; byte_data = 8'h11; byte_tx = 1;
        tick("R8");
        check("R8", crc_value == good && !pec_en && !pec_send, "stop", crc_value, good);

        // R9 arbitration loss
        arm("R9");
        send(8'h22, 1, 0, "R2");
        arb_lost = 1; tick("R9");
        check("R9", crc_value == 0 && !pec_en, "arb lost", crc_value, 0);

        // R10 peripheral disabled: set ignored
        send(8'h66, 1, 0, "R2");
        core_en = 0; pec_set = 1; tick("R10");
        check("R10", !pec_en && crc_value == 0, "disabled", pec_en, 0);
        pec_set = 1; tick("R10");
        check("R10", !pec_en, "set while off", pec_en, 0);
        core_en = 1;
        arm("R10");
        check("R10", pec_en, "set after on", pec_en, 1);

        // R1 reset again mid-run
        rst_n = 0;
        @(posedge clk); @(negedge clk);
        m_crc = 0; m_en = 0; m_send = 0; m_nak = 0; m_err = 0;
        compare("R1");
        finish_run();
    end
endmodule